// File: doc/BRIEF.md
# Capacitor Calibration Coefficient Calculator

This block turns the per-bit capacitor errors measured during a converter's self-calibration into cumulative correction coefficients. For each of the two capacitor arrays (plus side and minus side) it takes five signed error values, E0 to E4, for the five most significant bit capacitors, expressed in units of the 16-bit LSB. It produces five coefficients per side, CL0 to CL4, where each coefficient is a binary-weighted running sum of the errors. The sums are formed one coefficient per clock with shift-and-add arithmetic and are saturated to the output width.

In the single-run mode a start pulse captures both error sets, and a done pulse follows a fixed number of clock cycles later with all ten coefficients valid. The median mode handles noisy measurements. Over a chosen number of runs, each run's ten coefficients are kept in an internal run store. After the last run, for each coefficient, the block finds the value that sits in the middle of the stored set and outputs it. Together with the medians the block raises a spread flag when the CL0 value of either side has varied across the runs by more than a set limit.

Top module: `cal_coef_top`

## Requirements
- R1: While reset is asserted and after its release, until the first done, done_o and spread_o are 0 and every coefficient field of cl_pos_o and cl_neg_o is 0.
- R2: Errors are two's complement, Ei at bits [i*EW +: EW] of an error input. Coefficient CLk is at bits [k*OW +: OW] of an output. CL0 equals E0 and CL1 equals E0 + E1.
- R3: CL2 equals 2*E0 + E1 + E2, and CL3 equals 4*E0 + 2*E1 + E2 + E3.
- R4: CL4 equals 16*E0 + 8*E1 + 4*E2 + 2*E3 + E4.
- R5: cl_pos_o is computed only from err_pos_i and cl_neg_o only from err_neg_i, so the two sides give independent results from different error sets.
- R6: In single-run mode, done_o is a one-cycle pulse that goes high on the 6th rising edge after the edge that accepted start_i. The new coefficients appear in the same cycle.
- R7: A start_i that arrives while a computation or a median search is in progress is ignored. It causes no extra done and does not change the results.
- R8: A coefficient whose exact value lies outside the signed OW-bit range is clamped to the largest or the smallest OW-bit value.
- R9: median_i and runs_i are sampled only at the first start of a collection. A runs_i of 0 counts as 1, and a value above MAX_RUNS counts as MAX_RUNS. In median mode, after the n-th accepted run, done_o pulses and each of the ten outputs is the value at zero-based position floor((n-1)/2) of that coefficient's n results sorted in ascending order.
- R10: While a median collection is in progress done_o stays 0. The coefficient outputs change only in a cycle in which done_o is high.
- R11: At a median-mode done, spread_o is 1 exactly when max minus min of CL0 over the collected runs exceeds VAR_LIMIT (default 3) on either side. A single-run done clears spread_o. spread_o changes only when done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures both error sets when the block is idle |
| median_i | input | 1 | Selects median mode at the first start of a collection |
| runs_i | input | $clog2(MAX_RUNS+1) | Number of runs for a median collection |
| err_pos_i | input | 5*EW | Plus-side errors E0..E4 |
| err_neg_i | input | 5*EW | Minus-side errors E0..E4 |
| cl_pos_o | output | 5*OW | Plus-side coefficients CL0..CL4 |
| cl_neg_o | output | 5*OW | Minus-side coefficients CL0..CL4 |
| spread_o | output | 1 | CL0 variation across runs above the limit |
| done_o | output | 1 | One-cycle pulse when results are valid |

## Verification
The properties assume that each accepted start is followed by its own done before another start can be taken, and that the error inputs are read only on the accepting edge. The checker therefore captures the errors at that edge rather than relying on the inputs staying stable. They also assume that the first start of a median collection alone fixes the mode. The stimulus respects both: starts are issued only after the previous done or after enough idle cycles. The one deliberate start inside a busy window, along with the mid-collection changes to median_i and runs_i, tests whether these are ignored. Error values are always full-range 8-bit codes, so a narrow-output instance sees both saturation limits while the default instance never saturates.

// File: rtl/cal_coef_pkg.sv
package cal_coef_pkg;

  // coefficients (and measured capacitor errors) per side
  localparam int NCOEF = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_FIN,
    ST_MED
  } cal_state_e;

  // Error Ei takes part in coefficient CLk when i <= k.
  function automatic logic coef_uses(input int unsigned k, input int unsigned i);
    return (i <= k);
  endfunction

  // Left shift (power-of-two weight) applied to Ei inside CLk.
  function automatic int unsigned coef_shift(input int unsigned k, input int unsigned i);
    int unsigned sh;
    if (k == NCOEF - 1)         sh = k - i;
    else if (i + 2 <= k)        sh = k - 1 - i;
    else                        sh = 0;
    return sh;
  endfunction

endpackage

// File: rtl/cal_coef_term.sv
module cal_coef_term
  import cal_coef_pkg::*;
#(
  parameter int EW = 8,
  parameter int OW = 16
) (
  input  logic [NCOEF*EW-1:0] err_i,
  input  logic [2:0]          k_i,
  output logic [OW-1:0]       coef_o
);

  // wide enough for 31 * (-2^(EW-1)) with headroom
  localparam int SW = EW + 6;

  logic signed [SW-1:0] acc;

  always_comb begin
    logic signed [SW-1:0] ext;
    acc = '0;
    for (int i = 0; i < NCOEF; i++) begin
      ext = SW'($signed(err_i[i*EW +: EW]));
      if (coef_uses(32'(k_i), i)) begin
        acc = acc + (ext <<< coef_shift(32'(k_i), i));
      end
    end
  end

  generate
    if (OW >= SW) begin : g_wide
      assign coef_o = OW'(acc);
    end else begin : g_clamp
      localparam logic signed [SW-1:0] HI = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [SW-1:0] LO = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      always_comb begin
        if (acc > HI)      coef_o = HI[OW-1:0];
        else if (acc < LO) coef_o = LO[OW-1:0];
        else               coef_o = acc[OW-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/cal_coef_median.sv
module cal_coef_median #(
  parameter int OW        = 16,
  parameter int NREG      = 10,
  parameter int MAX_RUNS  = 40,
  parameter int VAR_LIMIT = 3,
  parameter int RW        = 6,
  parameter int IW        = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic [NREG*OW-1:0] wr_data_i,
  input  logic               go_i,
  input  logic [RW-1:0]      n_i,
  output logic               fin_o,
  output logic [NREG*OW-1:0] med_o,
  output logic               spread_o
);

  localparam int RRW  = $clog2(NREG);
  localparam int HALF = NREG / 2;
  localparam logic signed [OW:0] LIM = (OW+1)'(VAR_LIMIT);

  logic [OW-1:0] run_q [MAX_RUNS][NREG];
  logic signed [OW-1:0] mn_q [2];
  logic signed [OW-1:0] mx_q [2];

  logic            act_q, act_d, fin_q, fin_d;
  logic [RRW-1:0]  r_q, r_d;
  logic [IW-1:0]   i_q, i_d, j_q, j_d;
  logic [RW-1:0]   lt_q, lt_d, le_q, le_d;
  logic [NREG*OW-1:0] med_q, med_d;

  logic [OW-1:0] a_v, c_v;
  logic [RW-1:0] lt_n, le_n, kk;
  logic          last_j, last_i, last_r, hit;

  // run store, written once per run
  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int r = 0; r < NREG; r++) begin
        run_q[wr_idx_i][r] <= wr_data_i[r*OW +: OW];
      end
    end
  end

  // CL0 extremes of both sides over the collection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++) begin
        mn_q[s] <= '0;
        mx_q[s] <= '0;
      end
    end else if (wr_i) begin
      for (int s = 0; s < 2; s++) begin
        if (wr_idx_i == '0) begin
          mn_q[s] <= $signed(wr_data_i[s*HALF*OW +: OW]);
          mx_q[s] <= $signed(wr_data_i[s*HALF*OW +: OW]);
        end else begin
          if ($signed(wr_data_i[s*HALF*OW +: OW]) < mn_q[s]) mn_q[s] <= $signed(wr_data_i[s*HALF*OW +: OW]);
          if ($signed(wr_data_i[s*HALF*OW +: OW]) > mx_q[s]) mx_q[s] <= $signed(wr_data_i[s*HALF*OW +: OW]);
        end
      end
    end
  end

  always_comb begin
    logic signed [OW:0] dif;
    spread_o = 1'b0;
    for (int s = 0; s < 2; s++) begin
      dif = (OW+1)'(mx_q[s]) - (OW+1)'(mn_q[s]);
      if (dif > LIM) spread_o = 1'b1;
    end
  end

  // rank search: candidate i is the median when exactly the right
  // number of stored values lie below / at or below it
  assign a_v    = run_q[j_q][r_q];
  assign c_v    = run_q[i_q][r_q];
  assign kk     = (n_i - RW'(1)) >> 1;
  assign lt_n   = lt_q + RW'($signed(a_v) <  $signed(c_v));
  assign le_n   = le_q + RW'($signed(a_v) <= $signed(c_v));
  assign last_j = (RW'(j_q) == n_i - RW'(1));
  assign last_i = (RW'(i_q) == n_i - RW'(1));
  assign last_r = (r_q == RRW'(NREG - 1));
  assign hit    = act_q && last_j && (lt_n <= kk) && (le_n > kk);

  always_comb begin
    act_d = act_q;
    fin_d = 1'b0;
    r_d   = r_q;
    i_d   = i_q;
    j_d   = j_q;
    lt_d  = lt_q;
    le_d  = le_q;
    med_d = med_q;
    if (hit) med_d[r_q*OW +: OW] = c_v;
    if (go_i) begin
      act_d = 1'b1;
      r_d   = '0;
      i_d   = '0;
      j_d   = '0;
      lt_d  = '0;
      le_d  = '0;
    end else if (act_q) begin
      if (last_j) begin
        j_d  = '0;
        lt_d = '0;
        le_d = '0;
        if (last_i) begin
          i_d = '0;
          if (last_r) begin
            act_d = 1'b0;
            fin_d = 1'b1;
          end else begin
            r_d = r_q + RRW'(1);
          end
        end else begin
          i_d = i_q + IW'(1);
        end
      end else begin
        j_d  = j_q + IW'(1);
        lt_d = lt_n;
        le_d = le_n;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      fin_q <= 1'b0;
      r_q   <= '0;
      i_q   <= '0;
      j_q   <= '0;
      lt_q  <= '0;
      le_q  <= '0;
      med_q <= '0;
    end else begin
      act_q <= act_d;
      fin_q <= fin_d;
      if (go_i || act_q) begin
        r_q  <= r_d;
        i_q  <= i_d;
        j_q  <= j_d;
        lt_q <= lt_d;
        le_q <= le_d;
      end
      if (hit) med_q <= med_d;
    end
  end

  assign fin_o = fin_q;
  assign med_o = med_q;

endmodule

// File: rtl/cal_coef_top.sv
module cal_coef_top
  import cal_coef_pkg::*;
#(
  parameter int EW        = 8,
  parameter int OW        = 16,
  parameter int MAX_RUNS  = 40,
  parameter int VAR_LIMIT = 3,
  localparam int RW       = $clog2(MAX_RUNS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                median_i,
  input  logic [RW-1:0]       runs_i,
  input  logic [NCOEF*EW-1:0] err_pos_i,
  input  logic [NCOEF*EW-1:0] err_neg_i,
  output logic [NCOEF*OW-1:0] cl_pos_o,
  output logic [NCOEF*OW-1:0] cl_neg_o,
  output logic                spread_o,
  output logic                done_o
);

  localparam int IW   = (MAX_RUNS > 1) ? $clog2(MAX_RUNS) : 1;
  localparam int NREG = 2 * NCOEF;
  localparam int CW   = NCOEF * OW;

  cal_state_e       st_q, st_d;
  logic [2:0]       k_q, k_d;
  logic [NCOEF*EW-1:0] ep_q, en_q;
  logic [CW-1:0]    rp_q, rp_d, rn_q, rn_d, op_q, op_d, on_q, on_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [RW-1:0]    runs_q, runs_d, runs_eff;
  logic             med_mode_q, med_mode_d, done_q, done_d, spr_q, spr_d;
  logic             accept, wr, go, mfin, mspread;
  logic [NREG*OW-1:0] med_v;
  logic [OW-1:0]    term_v [2];

  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    if (runs_i == '0)                   runs_eff = RW'(1);
    else if (runs_i > RW'(MAX_RUNS))    runs_eff = RW'(MAX_RUNS);
    else                                runs_eff = runs_i;
  end

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      cal_coef_term #(.EW(EW), .OW(OW)) u_term (
        .err_i  ((s == 0) ? ep_q : en_q),
        .k_i    (k_q),
        .coef_o (term_v[s])
      );
    end
  endgenerate

  cal_coef_median #(
    .OW(OW), .NREG(NREG), .MAX_RUNS(MAX_RUNS), .VAR_LIMIT(VAR_LIMIT), .RW(RW), .IW(IW)
  ) u_med (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_idx_i  (idx_q),
    .wr_data_i ({rn_q, rp_q}),
    .go_i      (go),
    .n_i       (runs_q),
    .fin_o     (mfin),
    .med_o     (med_v),
    .spread_o  (mspread)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    k_d        = k_q;
    rp_d       = rp_q;
    rn_d       = rn_q;
    op_d       = op_q;
    on_d       = on_q;
    idx_d      = idx_q;
    runs_d     = runs_q;
    med_mode_d = med_mode_q;
    spr_d      = spr_q;
    done_d     = 1'b0;
    wr         = 1'b0;
    go         = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_CALC;
          k_d  = '0;
          if (idx_q == '0) begin
            med_mode_d = median_i;
            runs_d     = runs_eff;
          end
        end
      end
      ST_CALC: begin
        rp_d[k_q*OW +: OW] = term_v[0];
        rn_d[k_q*OW +: OW] = term_v[1];
        k_d = k_q + 3'd1;
        if (k_q == 3'(NCOEF - 1)) st_d = ST_FIN;
      end
      ST_FIN: begin
        if (!med_mode_q) begin
          op_d   = rp_q;
          on_d   = rn_q;
          spr_d  = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          wr = 1'b1;
          if (RW'(idx_q) == runs_q - RW'(1)) begin
            idx_d = '0;
            go    = 1'b1;
            st_d  = ST_MED;
          end else begin
            idx_d = idx_q + IW'(1);
            st_d  = ST_IDLE;
          end
        end
      end
      ST_MED: begin
        if (mfin) begin
          op_d   = med_v[0 +: CW];
          on_d   = med_v[CW +: CW];
          spr_d  = mspread;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control and output registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      k_q        <= '0;
      idx_q      <= '0;
      runs_q     <= RW'(1);
      med_mode_q <= 1'b0;
      op_q       <= '0;
      on_q       <= '0;
      spr_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      k_q        <= k_d;
      idx_q      <= idx_d;
      runs_q     <= runs_d;
      med_mode_q <= med_mode_d;
      done_q     <= done_d;
      if (done_d) begin
        op_q  <= op_d;
        on_q  <= on_d;
        spr_q <= spr_d;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk_i) begin
    if (accept) begin
      ep_q <= err_pos_i;
      en_q <= err_neg_i;
    end
    if (st_q == ST_CALC) begin
      rp_q <= rp_d;
      rn_q <= rn_d;
    end
  end

  assign cl_pos_o = op_q;
  assign cl_neg_o = on_q;
  assign spread_o = spr_q;
  assign done_o   = done_q;

endmodule

// File: rtl/cal_coef_chk.sv
module cal_coef_chk #(
  parameter int EW = 8,
  parameter int OW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          accept_i,
  input logic          med_mode_i,
  input logic [5*EW-1:0] err_pos_i,
  input logic [5*OW-1:0] cl_pos_i,
  input logic [5*OW-1:0] cl_neg_i,
  input logic          spread_i,
  input logic          done_i
);

  logic [3:0]    cnt_q;
  logic [EW-1:0] cap0_q, cap1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cap0_q <= '0;
      cap1_q <= '0;
    end else if (accept_i) begin
      cnt_q  <= 4'd1;
      cap0_q <= err_pos_i[0 +: EW];
      cap1_q <= err_pos_i[EW +: EW];
    end else if (cnt_q != 4'd0 && cnt_q != 4'd15) begin
      cnt_q <= cnt_q + 4'd1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R6
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !med_mode_i) |-> (cnt_q == 4'd7));

  // R2
  low_coef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !med_mode_i) |->
      ($signed(cl_pos_i[0 +: OW]) == $signed(cap0_q)) &&
      ($signed(cl_pos_i[OW +: OW]) == $signed(cap0_q) + $signed(cap1_q)));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 4'd0 && cnt_q < 4'd7 && !med_mode_i) |-> !accept_i);

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_i || ($stable(cl_pos_i) && $stable(cl_neg_i))));

  // R11
  spread_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_i || $stable(spread_i)));

  // R11
  single_spread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !med_mode_i) |-> !spread_i);

endmodule

bind cal_coef_top cal_coef_chk #(.EW(EW), .OW(OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accept_i   (accept),
  .med_mode_i (med_mode_q),
  .err_pos_i  (err_pos_i),
  .cl_pos_i   (cl_pos_o),
  .cl_neg_i   (cl_neg_o),
  .spread_i   (spread_o),
  .done_i     (done_o)
);

// File: tb/cal_coef_top_tb.sv
module cal_coef_top_tb;

  localparam int SOW = 10;

  logic        clk = 1'b0;
  logic        rst_n, start, median;
  logic [5:0]  runs;
  logic [39:0] epv, env;
  logic [79:0] clp, cln;
  logic        spr, done;
  logic [49:0] sclp, scln;
  logic        sspr, sdone;

  always #10 clk = ~clk;

  cal_coef_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .median_i(median), .runs_i(runs),
    .err_pos_i(epv), .err_neg_i(env), .cl_pos_o(clp), .cl_neg_o(cln),
    .spread_o(spr), .done_o(done)
  );

  cal_coef_top #(.OW(SOW), .MAX_RUNS(4)) u_sat (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .median_i(1'b0), .runs_i(3'd1),
    .err_pos_i(epv), .err_neg_i(env), .cl_pos_o(sclp), .cl_neg_o(scln),
    .spread_o(sspr), .done_o(sdone)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int rng     = 32'h1234_5678;
  int md_p [40][5];
  int md_n [40][5];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s8(input int x);
    return int'($signed(8'(x)));
  endfunction

  function automatic int rnd8();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return s8(rng);
  endfunction

  function automatic int gold(input int e[5], input int k);
    case (k)
      0:       return e[0];
      1:       return e[0] + e[1];
      2:       return e[2] + e[1] + 2*e[0];
      3:       return e[3] + e[2] + 2*e[1] + 4*e[0];
      default: return e[4] + 2*e[3] + 4*e[2] + 8*e[1] + 16*e[0];
    endcase
  endfunction

  function automatic int clampv(input int v, input int w);
    int hi = (1 << (w-1)) - 1;
    int lo = -(1 << (w-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [39:0] pack(input int e[5]);
    logic [39:0] p;
    for (int i = 0; i < 5; i++) p[i*8 +: 8] = 8'(e[i]);
    return p;
  endfunction

  function automatic int f16(input logic [79:0] v, input int k);
    return int'($signed(v[k*16 +: 16]));
  endfunction

  function automatic int f10(input logic [49:0] v, input int k);
    return int'($signed(v[k*10 +: 10]));
  endfunction

  function automatic string req_of(input int k);
    if (k < 2) return "R2";
    if (k < 4) return "R3";
    return "R4";
  endfunction

  task automatic check_single(input int ep[5], input int en[5]);
    for (int k = 0; k < 5; k++) begin
      chk(f16(clp, k) == gold(ep, k), {req_of(k), " plus"}, f16(clp, k), gold(ep, k));
      chk(f16(cln, k) == gold(en, k), {req_of(k), "/R5 minus"}, f16(cln, k), gold(en, k));
      chk(f10(sclp, k) == clampv(gold(ep, k), SOW), "R8 plus", f10(sclp, k), clampv(gold(ep, k), SOW));
      chk(f10(scln, k) == clampv(gold(en, k), SOW), "R8 minus", f10(scln, k), clampv(gold(en, k), SOW));
    end
    chk(spr == 1'b0, "R11 single clears", int'(spr), 0);
  endtask

  // one single-mode run; optional start inside the busy window (R7)
  task automatic single(input int ep[5], input int en[5], input bit intrude);
    epv = pack(ep); env = pack(en); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 early done", int'(done), 0);
      if (intrude && c == 2) begin
        epv = ~epv; env = ~env; start = 1'b1;
      end
      if (intrude && c == 3) start = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 done on 6th edge", int'(done), 1);
    check_single(ep, en);
    @(negedge clk);
    chk(done == 1'b0, "R6 one-cycle pulse", int'(done), 0);
    if (intrude) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        chk(done == 1'b0, "R7 no extra done", int'(done), 0);
      end
      check_single(ep, en);
    end
  endtask

  // median collection of n effective runs from md_p/md_n
  task automatic median_run(input int n, input int runs_val);
    logic [79:0] snap_p, snap_n;
    int v[40];
    int wait_c, t, mn0, mx0, mn1, mx1;
    bit got;
    snap_p = clp; snap_n = cln;
    for (int r = 0; r < n; r++) begin
      epv = pack(md_p[r]); env = pack(md_n[r]);
      median = (r == 0); runs = (r == 0) ? 6'(runs_val) : 6'd7;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 7; c++) begin
        @(negedge clk);
        chk(done == 1'b0, "R10 no done in collection", int'(done), 0);
        chk(clp == snap_p && cln == snap_n, "R10 outputs hold", 0, 0);
      end
    end
    median = 1'b0;
    got = 1'b0;
    wait_c = 10*n*n + 20;
    for (int c = 0; c < wait_c && !got; c++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk(got, "R9 median done", int'(got), 1);
    for (int r = 0; r < 10; r++) begin
      for (int j = 0; j < n; j++) v[j] = (r < 5) ? gold(md_p[j], r) : gold(md_n[j], r - 5);
      for (int a = 0; a < n; a++)
        for (int b = 0; b + 1 < n - a; b++)
          if (v[b] > v[b+1]) begin t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
      if (r < 5) chk(f16(clp, r) == v[(n-1)/2], "R9 median plus", f16(clp, r), v[(n-1)/2]);
      else       chk(f16(cln, r-5) == v[(n-1)/2], "R9 median minus", f16(cln, r-5), v[(n-1)/2]);
    end
    mn0 = md_p[0][0]; mx0 = mn0; mn1 = md_n[0][0]; mx1 = mn1;
    for (int j = 1; j < n; j++) begin
      if (md_p[j][0] < mn0) mn0 = md_p[j][0];
      if (md_p[j][0] > mx0) mx0 = md_p[j][0];
      if (md_n[j][0] < mn1) mn1 = md_n[j][0];
      if (md_n[j][0] > mx1) mx1 = md_n[j][0];
    end
    chk(spr == ((mx0 - mn0 > 3) || (mx1 - mn1 > 3)), "R11 spread flag",
        int'(spr), int'((mx0 - mn0 > 3) || (mx1 - mn1 > 3)));
    @(negedge clk);
    chk(done == 1'b0, "R6 median done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ep[5], en[5];
    rst_n = 1'b0; start = 1'b0; median = 1'b0; runs = 6'd0; epv = '0; env = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && spr == 1'b0, "R1 in reset flags", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(spr == 1'b0, "R1 spread after reset", int'(spr), 0);
    chk(clp == '0 && cln == '0, "R1 outputs zero", 0, 0);

    // corners: all max, all min, mixed
    for (int i = 0; i < 5; i++) begin ep[i] = 127; en[i] = -128; end
    single(ep, en, 1'b0);
    for (int i = 0; i < 5; i++) begin ep[i] = -128; en[i] = 127; end
    single(ep, en, 1'b0);
    for (int i = 0; i < 5; i++) begin ep[i] = (i % 2) ? -128 : 127; en[i] = 0; end
    single(ep, en, 1'b0);

    // sweep E0 over every code, other errors derived from it
    for (int a = -128; a < 128; a++) begin
      ep[0] = a;        ep[1] = s8(3*a + 1); ep[2] = s8(-a); ep[3] = s8(a >>> 1); ep[4] = s8(a ^ 85);
      en[0] = s8(-a-1); en[1] = s8(a + 64);  en[2] = s8(5*a); en[3] = a;         en[4] = s8(127 - a);
      single(ep, en, 1'b0);
    end

    // random patterns
    for (int r = 0; r < 80; r++) begin
      for (int i = 0; i < 5; i++) begin ep[i] = rnd8(); en[i] = rnd8(); end
      single(ep, en, 1'b0);
    end

    // start while busy is dropped
    for (int i = 0; i < 5; i++) begin ep[i] = 17*i - 40; en[i] = 30 - 9*i; end
    single(ep, en, 1'b1);

    // median, odd count, wide spread
    for (int j = 0; j < 5; j++)
      for (int i = 0; i < 5; i++) begin md_p[j][i] = rnd8(); md_n[j][i] = rnd8(); end
    median_run(5, 5);

    // median, even count: lower middle value
    for (int j = 0; j < 4; j++)
      for (int i = 0; i < 5; i++) begin md_p[j][i] = rnd8(); md_n[j][i] = rnd8(); end
    md_p[0][0] = 10; md_p[1][0] = -3; md_p[2][0] = 7; md_p[3][0] = 2;
    median_run(4, 4);

    // run count 0 counts as one run
    for (int i = 0; i < 5; i++) begin md_p[0][i] = rnd8(); md_n[0][i] = rnd8(); end
    median_run(1, 0);

    // full count, CL0 variation exactly at the limit on both sides
    for (int j = 0; j < 40; j++) begin
      for (int i = 0; i < 5; i++) begin md_p[j][i] = rnd8(); md_n[j][i] = rnd8(); end
      md_p[j][0] = 5 + (j % 4);
      md_n[j][0] = -2 + ((j * 3) % 4);
    end
    median_run(40, 40);

    // count above the maximum is clamped; variation one above the limit
    for (int j = 0; j < 40; j++) begin
      for (int i = 0; i < 5; i++) begin md_p[j][i] = rnd8(); md_n[j][i] = rnd8(); end
      md_p[j][0] = j % 5;
      md_n[j][0] = 1;
    end
    median_run(40, 63);

    // back to single mode: spread cleared
    for (int i = 0; i < 5; i++) begin ep[i] = i - 2; en[i] = 2 - i; end
    single(ep, en, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule